// File: doc/BRIEF.md
# Register-Mapped Serial Port with Interrupts

This block is a small serial port on a 32-bit register bus. It has a transmitter and a receiver that use a fixed frame: one start bit, eight data bits with the least significant bit first, no parity and one stop bit. Each direction holds a single byte. Software writes a byte to the data register. The transmitter moves that byte into its shifter and sends it out. The receiver captures one byte into a holding register, and software reads it back from the same data address.

The bit time is set by a divider register. The divider gives the number of clock cycles in each serial bit. Three interrupt lines leave the block: one for transmit, one for receive, and one that combines both overrun sources. Each line is masked by its own enable bit. Interrupt flags are cleared by writing ones to them.

The bus has no wait states. A read returns data combinationally in the cycle `bus_valid` is high. A write takes effect at the next clock edge. Registers sit on 32-bit word boundaries: data at 0x00, status at 0x04, control at 0x08, interrupt at 0x0C and divider at 0x10.

Top module: `mmio_uart`

## Requirements
- R1: After reset, every register reads zero, `txd` is high and all three interrupt outputs are low.
- R2: Control (6 bits) and divider (21 bits) read back what was written. Bits above their width read zero.
- R3: With transmit enabled, a buffered byte is sent as a low start bit, then data bit 0 through bit 7, then a high stop bit. Each bit lasts exactly divider clock cycles. The line stays high between frames.
- R4: Status bit 0 is high while the transmit buffer holds a byte. A data write while that bit is high sets status bit 2 and interrupt bit 2. The written byte is discarded and the buffered byte is sent unchanged.
- R5: The receiver needs receive enable. It latches a correctly framed byte (stop bit high) and sets status bit 1. A data read returns that byte in bits 7:0 and clears status bit 1.
- R6: A byte that completes while status bit 1 is still high sets status bit 3 and interrupt bit 3. The held byte is kept.
- R7: Interrupt bit 0 sets when the transmit buffer hands its byte to the shifter. Interrupt bit 1 sets when a byte is latched into the receive buffer.
- R8: In the interrupt register, writing 1 to a bit clears it and writing 0 leaves it unchanged. Status bits 2 and 3 clear the same way when written at the status address.
- R9: `irq_tx` is interrupt bit 0 AND control bit 2. `irq_rx` is interrupt bit 1 AND control bit 3. `irq_ovr` is (interrupt bit 2 AND control bit 4) OR (interrupt bit 3 AND control bit 5).
- R10: With control bit 0 low, a buffered byte stays buffered and `txd` stays high. With control bit 1 low, activity on `rxd` latches nothing.
- R11: A low pulse on `rxd` that ends before half a bit period is treated as noise. No byte is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq_tx | output | 1 | Masked transmit interrupt |
| irq_rx | output | 1 | Masked receive interrupt |
| irq_ovr | output | 1 | Masked combined overrun interrupt |

## Verification
A wrong bit counter or divider compare in the transmitter shows on `txd` as a frame that is too long or too short. It appears within one bit time of the first bad bit. A fault in the receive sampling point or the shift direction shows as a wrong byte at the next data read after a frame. A fault in flag set or clear priority shows in the next interrupt or status read, and on the gated interrupt lines one cycle after the write that exposes it.

// File: rtl/mmio_uart.sv
module mmio_uart #(
  parameter int AW   = 5,
  parameter int DIVW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          rxd,
  output logic          txd,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          irq_ovr
);
  localparam int FRAME = 10;

  logic [5:0]      ctrl;
  logic [DIVW-1:0] div;
  logic [3:0]      intf;
  logic            st_txo, st_rxo;
  logic [7:0]      tx_buf, rx_buf, rx_sh;
  logic            tx_full, rx_full;
  logic [9:0]      tx_sh;
  logic [3:0]      tx_bits, rx_n;
  logic [DIVW-1:0] tx_cnt, rx_cnt;
  logic [1:0]      rx_sync;

  wire sel_data = bus_addr == AW'('h00);
  wire sel_st   = bus_addr == AW'('h04);
  wire sel_ctrl = bus_addr == AW'('h08);
  wire sel_int  = bus_addr == AW'('h0C);
  wire sel_div  = bus_addr == AW'('h10);
  wire wr       = bus_valid & bus_write;
  wire rd_data  = bus_valid & ~bus_write & sel_data;
  wire unused_hi = &{1'b0, bus_wdata[31:DIVW]};

  wire tx_busy   = tx_bits != 4'd0;
  wire tx_load   = ctrl[0] & tx_full & ~tx_busy;
  wire tx_tick   = tx_cnt == div - DIVW'(1);
  wire tx_ovr_ev = wr & sel_data & tx_full;

  wire rx_in     = rx_sync[1];
  wire rx_tick   = (rx_n == 4'd1) ? (rx_cnt == (div >> 1)) : (rx_cnt == div - DIVW'(1));
  wire rx_done   = ctrl[1] & (rx_n == 4'(FRAME)) & rx_tick & rx_in;
  wire rx_new    = rx_done & ~rx_full;
  wire rx_ovr_ev = rx_done & rx_full;

  wire [3:0] int_clr = (wr & sel_int) ? bus_wdata[3:0] : 4'd0;
  wire [3:0] int_set = {rx_ovr_ev, tx_ovr_ev, rx_new, tx_load};

  assign txd     = tx_busy ? tx_sh[0] : 1'b1;
  assign irq_tx  = intf[0] & ctrl[2];
  assign irq_rx  = intf[1] & ctrl[3];
  assign irq_ovr = (intf[2] & ctrl[4]) | (intf[3] & ctrl[5]);

  always_comb begin
    bus_rdata = '0;
    if (sel_data) bus_rdata[7:0] = rx_buf;
    if (sel_st)   bus_rdata[3:0] = {st_rxo, st_txo, rx_full, tx_full};
    if (sel_ctrl) bus_rdata[5:0] = ctrl;
    if (sel_int)  bus_rdata[3:0] = intf;
    if (sel_div)  bus_rdata[DIVW-1:0] = div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; div <= '0; intf <= '0; st_txo <= 1'b0; st_rxo <= 1'b0;
      tx_buf <= '0; tx_full <= 1'b0; tx_sh <= '0; tx_bits <= '0; tx_cnt <= '0;
    end else begin
      if (wr & sel_ctrl) ctrl <= bus_wdata[5:0];
      if (wr & sel_div)  div  <= bus_wdata[DIVW-1:0];
      intf   <= (intf & ~int_clr) | int_set;
      st_txo <= (st_txo & ~(wr & sel_st & bus_wdata[2])) | tx_ovr_ev;
      st_rxo <= (st_rxo & ~(wr & sel_st & bus_wdata[3])) | rx_ovr_ev;
      if (wr & sel_data & ~tx_full) begin
        tx_buf  <= bus_wdata[7:0];
        tx_full <= 1'b1;
      end else if (tx_load) begin
        tx_full <= 1'b0;
      end
      if (tx_load) begin
        tx_sh   <= {1'b1, tx_buf, 1'b0};
        tx_bits <= 4'(FRAME);
        tx_cnt  <= '0;
      end else if (tx_busy) begin
        if (tx_tick) begin
          tx_cnt  <= '0;
          tx_sh   <= {1'b1, tx_sh[9:1]};
          tx_bits <= tx_bits - 4'd1;
        end else begin
          tx_cnt <= tx_cnt + DIVW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= 2'b11; rx_n <= '0; rx_cnt <= '0; rx_sh <= '0;
      rx_buf <= '0; rx_full <= 1'b0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      if (!ctrl[1]) begin
        rx_n <= '0;
      end else if (rx_n == 4'd0) begin
        if (!rx_in) begin
          rx_n   <= 4'd1;
          rx_cnt <= '0;
        end
      end else if (rx_tick) begin
        rx_cnt <= '0;
        if ((rx_n == 4'd1 && rx_in) || rx_n == 4'(FRAME)) rx_n <= '0;
        else rx_n <= rx_n + 4'd1;
        if (rx_n >= 4'd2 && rx_n <= 4'd9) rx_sh <= {rx_in, rx_sh[7:1]};
      end else begin
        rx_cnt <= rx_cnt + DIVW'(1);
      end
      if (rx_new) begin
        rx_buf  <= rx_sh;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end
    end
  end

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
  p_overrun_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovr_ev |=> (st_txo && intf[2] && tx_full));
  p_rx_flag_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intf[1]) |-> rx_full);
  p_tx_flag_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_full) |-> (intf[0] && tx_busy));
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !tx_busy) |=> !tx_busy);
  p_rx_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[1] |=> (rx_n == 4'd0));
endmodule

// File: tb/mmio_uart_test.sv
`timescale 1ns/1ps
module mmio_uart_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rxd = 1'b1, txd, irq_tx, irq_rx, irq_ovr;
  int nvec = 0, nbad = 0;

  mmio_uart uut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd),
    .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr));

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [31:0] exp_st(logic tf, logic rf, logic to, logic ro);
    return {28'd0, ro, to, rf, tf};
  endfunction

  function automatic logic [31:0] exp_frame(logic [7:0] b);
    return {22'd0, 1'b1, b, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_valid = 1'b0;
  endtask

  task automatic watch_tx(input int d, output logic [31:0] fr);
    int guard = 0;
    fr = '1;
    @(negedge clk);
    while (txd === 1'b1 && guard < 3000) begin @(negedge clk); guard++; end
    repeat (d/2) @(negedge clk);
    fr[0] = txd;
    for (int i = 1; i < 10; i++) begin
      repeat (d) @(negedge clk);
      fr[i] = txd;
    end
    fr[31:10] = '0;
    repeat (d) @(negedge clk);
  endtask

  task automatic send_rx(input int d, input logic [7:0] b);
    logic [9:0] f = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (d-1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] v, fr;
    logic [7:0] b;
    int d, seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 txd idle", {31'd0, txd}, 32'd1);
    check("R1 irqs", {29'd0, irq_tx, irq_rx, irq_ovr}, 32'd0);
    rd(5'h04, v); check("R1 status", v, 32'd0);
    rd(5'h08, v); check("R1 ctrl", v, 32'd0);
    rd(5'h0C, v); check("R1 int", v, 32'd0);
    rd(5'h10, v); check("R1 div", v, 32'd0);
    rd(5'h00, v); check("R1 data", v, 32'd0);

    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, v); check("R2 ctrl mask", v, 32'h3F);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, v); check("R2 div mask", v, 32'h1F_FFFF);
    wr(5'h08, 32'h0); wr(5'h10, 32'd16);

    wr(5'h00, 32'hA5); wr(5'h00, 32'h3C);
    repeat (40) @(negedge clk);
    check("R10 tx held txd", {31'd0, txd}, 32'd1);
    rd(5'h04, v); check("R4 full+ovr status", v, exp_st(1, 0, 1, 0));
    rd(5'h0C, v); check("R4 int ovr", v, 32'h4);
    check("R9 ovr masked", {31'd0, irq_ovr}, 32'd0);
    wr(5'h08, 32'h10);
    check("R9 ovr enabled", {31'd0, irq_ovr}, 32'd1);
    wr(5'h0C, 32'h0); rd(5'h0C, v); check("R8 write zero keeps", v, 32'h4);
    wr(5'h0C, 32'h4); rd(5'h0C, v); check("R8 w1c int", v, 32'h0);
    check("R9 ovr cleared", {31'd0, irq_ovr}, 32'd0);
    wr(5'h04, 32'h4); rd(5'h04, v); check("R8 w1c status", v, exp_st(1, 0, 0, 0));

    wr(5'h08, 32'h01);
    watch_tx(16, fr); check("R3 R4 kept byte frame", fr, exp_frame(8'hA5));
    rd(5'h0C, v); check("R7 tx flag", v, 32'h1);
    check("R9 tx masked", {31'd0, irq_tx}, 32'd0);
    wr(5'h08, 32'h05); check("R9 tx enabled", {31'd0, irq_tx}, 32'd1);
    wr(5'h0C, 32'h1); check("R9 tx cleared", {31'd0, irq_tx}, 32'd0);

    send_rx(16, 8'h5A);
    repeat (5) @(negedge clk);
    rd(5'h04, v); check("R10 rx disabled", v, exp_st(0, 0, 0, 0));

    wr(5'h08, 32'h2A);
    @(negedge clk); rxd = 1'b0; repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (200) @(negedge clk);
    rd(5'h04, v); check("R11 glitch rejected", v, exp_st(0, 0, 0, 0));

    send_rx(16, 8'h96);
    repeat (5) @(negedge clk);
    rd(5'h04, v); check("R5 rx full", v, exp_st(0, 1, 0, 0));
    rd(5'h0C, v); check("R7 rx flag", v, 32'h2);
    check("R9 rx irq", {31'd0, irq_rx}, 32'd1);
    send_rx(16, 8'h11);
    repeat (5) @(negedge clk);
    rd(5'h04, v); check("R6 rx overrun", v, exp_st(0, 1, 0, 1));
    check("R9 ovr from rx", {31'd0, irq_ovr}, 32'd1);
    rd(5'h00, v); check("R6 kept byte", v, 32'h96);
    rd(5'h04, v); check("R5 full cleared", v, exp_st(0, 0, 0, 1));
    wr(5'h04, 32'h8); wr(5'h0C, 32'hF);
    rd(5'h04, v); check("R8 rx ovr status clear", v, 32'd0);

    wr(5'h08, 32'h03);
    for (int i = 0; i < 8; i++) begin
      d = 16 + $urandom_range(0, 24);
      wr(5'h10, d);
      b = 8'($urandom);
      wr(5'h00, {24'd0, b});
      watch_tx(d, fr); check("R3 random tx", fr, exp_frame(b));
      b = 8'($urandom);
      send_rx(d, b);
      repeat (5) @(negedge clk);
      rd(5'h04, v); check("R5 random status", v, exp_st(0, 1, 0, 0));
      rd(5'h00, v); check("R5 random rx", v, {24'd0, b});
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule